// File: doc/BRIEF.md
# Scoreboard Hazard Interlock Unit

This block is the central control point between an in-order instruction stream and four pipelined arithmetic units: add, multiply, divide and logic. Each unit has its own fixed latency. Instructions arrive already decoded, one per clock at most, over a valid/ready handshake. Each one names a unit, a destination register and two source registers, out of eight registers. The scoreboard decides three things. First, when an instruction may issue. Second, when a unit may read its operands. Third, when a finished unit may drive the single result write port. The register file, the datapath and the units themselves are outside the block. The units only report a one-cycle completion pulse.

A true (read-after-write) dependency does not hold up issue. The dependent instruction enters its unit and waits there until the producing unit has written back. Issue stalls in two cases: the target unit is occupied, or the destination already has an outstanding writer. A finished unit may not write back while any earlier instruction still has that register as an unread source. When several units can write in the same cycle, the one issued earliest wins.

Top module: `sb_interlock`

## Requirements
- R1: `issue_ready` is low while the selected unit (code 0 add, 1 multiply, 2 divide, 3 logic) still holds an instruction that has not been written back. The unit accepts a new instruction in the cycle after its `fu_wb` grant.
- R2: `issue_ready` is low while the requested destination register is the target of an outstanding, not yet written-back instruction.
- R3: An instruction whose source is the destination of an outstanding instruction is accepted without waiting for it. Its `fu_read` is asserted no earlier than the cycle after that producer's `fu_wb` grant, and exactly then if nothing else holds it.
- R4: `fu_read` for a unit is a single-cycle pulse per instruction. It is asserted in the first cycle in which both sources are available. The earliest such cycle is the cycle after the issue handshake.
- R5: With no blocking condition, instructions are accepted on consecutive clocks.
- R6: At most one bit of `fu_wb` is set in any cycle.
- R7: Among units that may write back in the same cycle, the one whose instruction was issued earliest is granted. The others follow in issue order on later cycles.
- R8: A finished unit is not granted while an earlier-issued instruction still has its destination as an unread source. The grant may come in the cycle after that read.
- R9: An uncontested unit is granted `fu_wb` in the cycle after its `fu_done` pulse. `fu_done` is pulsed by the unit a latency after its read.
- R10: After reset no unit is occupied and no register is pending: `issue_ready` is high, and `fu_read` and `fu_wb` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Decoded instruction present |
| issue_ready | output | 1 | Instruction accepted at this edge when valid |
| issue_unit | input | 2 | Target unit code |
| issue_dst | input | 3 | Destination register |
| issue_srca | input | 3 | First source register |
| issue_srcb | input | 3 | Second source register |
| fu_done | input | 4 | Per-unit completion pulse |
| fu_read | output | 4 | Per-unit operand read enable |
| fu_wb | output | 4 | Per-unit result write grant |

## Verification
The hardest condition to reach is a write-after-read hold. It needs a fast unit that finishes while an older instruction is still parked on a slow producer and has not yet read the register the fast unit wants to write. The bench builds this on purpose. It issues a long divide, then an add that depends on it, then a one-cycle logic operation that writes one of the add's sources, on three back-to-back clocks. Three-way write-port collisions are arranged by timing issue gaps against the known latencies. A cycle-accurate reference model in the bench then checks every cycle across an exhaustive pair sweep and a long pseudo-random stream.

// File: rtl/sb_pkg.sv
`timescale 1ns/1ps
package sb_pkg;
    localparam int NUM_UNITS = 4;
    localparam int NUM_REGS  = 8;
    localparam int NUM_SRC   = 2;
    localparam int REG_W     = $clog2(NUM_REGS);
    localparam int UNIT_W    = $clog2(NUM_UNITS);

    localparam int FU_ADD = 0;
    localparam int FU_MUL = 1;
    localparam int FU_DIV = 2;
    localparam int FU_LOG = 3;

    typedef logic [REG_W-1:0]  reg_idx_t;
    typedef logic [UNIT_W-1:0] unit_idx_t;

    // Per-unit record of the instruction it holds
    typedef struct packed {
        logic                          busy;
        logic                          opread;  // operands already taken
        logic                          fin;     // result computed, awaiting port
        reg_idx_t                      dst;
        reg_idx_t  [NUM_SRC-1:0]       src;
        unit_idx_t [NUM_SRC-1:0]       prod;
        logic      [NUM_SRC-1:0]       rdy;
        logic      [NUM_UNITS-1:0]     older;   // units issued before this one
    } unit_rec_t;

    typedef struct packed {
        logic      vld;
        unit_idx_t unit;
    } rstat_t;

    typedef struct packed {
        unit_rec_t [NUM_UNITS-1:0] fu;
        rstat_t    [NUM_REGS-1:0]  rs;
    } sb_state_t;
endpackage

// File: rtl/sb_issue_gate.sv
`timescale 1ns/1ps
module sb_issue_gate
    import sb_pkg::*;
(
    input  logic [NUM_UNITS-1:0] busy,
    input  logic [NUM_REGS-1:0]  dst_pend,
    input  unit_idx_t            unit,
    input  reg_idx_t             dst,
    output logic                 ready
);
    logic unit_free;
    logic dst_free;

    always_comb begin
        unit_free = !busy[unit];
        dst_free  = !dst_pend[dst];
        ready     = unit_free && dst_free;
    end
endmodule

// File: rtl/sb_wb_arbiter.sv
`timescale 1ns/1ps
module sb_wb_arbiter
    import sb_pkg::*;
(
    input  unit_rec_t [NUM_UNITS-1:0] fu,
    output logic      [NUM_UNITS-1:0] gnt,
    output logic                      gnt_any,
    output unit_idx_t                 gnt_idx
);
    logic [NUM_UNITS-1:0] war_hold;
    logic [NUM_UNITS-1:0] req;
    logic [NUM_UNITS-1:0] eldest;

    // Write-after-read hold: an older unit still owes a read of our dst
    always_comb begin
        for (int u = 0; u < NUM_UNITS; u++) begin
            war_hold[u] = 1'b0;
            for (int v = 0; v < NUM_UNITS; v++) begin
                if (v != u && fu[u].older[v] && fu[v].busy && !fu[v].opread) begin
                    for (int k = 0; k < NUM_SRC; k++) begin
                        if (fu[v].src[k] == fu[u].dst) war_hold[u] = 1'b1;
                    end
                end
            end
            req[u] = fu[u].busy && fu[u].fin && !war_hold[u];
        end
    end

    // Age filter, then fixed-index pick among survivors
    always_comb begin
        for (int u = 0; u < NUM_UNITS; u++) begin
            eldest[u] = req[u];
            for (int v = 0; v < NUM_UNITS; v++) begin
                if (v != u && req[v] && fu[u].older[v]) eldest[u] = 1'b0;
            end
        end
        gnt     = '0;
        gnt_any = 1'b0;
        gnt_idx = '0;
        for (int u = 0; u < NUM_UNITS; u++) begin
            if (eldest[u] && !gnt_any) begin
                gnt[u]  = 1'b1;
                gnt_any = 1'b1;
                gnt_idx = unit_idx_t'(u);
            end
        end
    end
endmodule

// File: rtl/sb_interlock.sv
`timescale 1ns/1ps
module sb_interlock
    import sb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 issue_valid,
    output logic                 issue_ready,
    input  logic [UNIT_W-1:0]    issue_unit,
    input  logic [REG_W-1:0]     issue_dst,
    input  logic [REG_W-1:0]     issue_srca,
    input  logic [REG_W-1:0]     issue_srcb,
    input  logic [NUM_UNITS-1:0] fu_done,
    output logic [NUM_UNITS-1:0] fu_read,
    output logic [NUM_UNITS-1:0] fu_wb
);
    sb_state_t st_q, st_d;

    logic [NUM_UNITS-1:0] busy_vec;
    logic [NUM_REGS-1:0]  dst_pend;
    logic                 gnt_any;
    unit_idx_t            gnt_idx;
    reg_idx_t [NUM_SRC-1:0] src_in;
    logic                 issue_fire;

    assign src_in[0] = issue_srca;
    assign src_in[1] = issue_srcb;

    generate
        for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
            assign busy_vec[u] = st_q.fu[u].busy;
            assign fu_read[u]  = st_q.fu[u].busy && !st_q.fu[u].opread && (&st_q.fu[u].rdy);
        end
        for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
            assign dst_pend[r] = st_q.rs[r].vld;
        end
    endgenerate

    sb_issue_gate gate_i (
        .busy     (busy_vec),
        .dst_pend (dst_pend),
        .unit     (issue_unit),
        .dst      (issue_dst),
        .ready    (issue_ready)
    );

    sb_wb_arbiter arb_i (
        .fu      (st_q.fu),
        .gnt     (fu_wb),
        .gnt_any (gnt_any),
        .gnt_idx (gnt_idx)
    );

    assign issue_fire = issue_valid && issue_ready;

    always_comb begin
        st_d = st_q;

        // Writeback: free the unit and its register, wake consumers
        if (gnt_any) begin
            st_d.fu[gnt_idx].busy   = 1'b0;
            st_d.fu[gnt_idx].opread = 1'b0;
            st_d.fu[gnt_idx].fin    = 1'b0;
            st_d.fu[gnt_idx].older  = '0;
            st_d.rs[st_q.fu[gnt_idx].dst].vld = 1'b0;
        end

        for (int u = 0; u < NUM_UNITS; u++) begin
            if (gnt_any) begin
                st_d.fu[u].older[gnt_idx] = 1'b0;
                for (int k = 0; k < NUM_SRC; k++) begin
                    if (st_q.fu[u].busy && !st_q.fu[u].rdy[k] &&
                        st_q.fu[u].prod[k] == gnt_idx) begin
                        st_d.fu[u].rdy[k] = 1'b1;
                    end
                end
            end
            if (fu_read[u]) st_d.fu[u].opread = 1'b1;
            if (fu_done[u] && st_q.fu[u].busy && st_q.fu[u].opread) st_d.fu[u].fin = 1'b1;
        end

        // Issue: capture operands' producers, claim destination
        if (issue_fire) begin
            st_d.fu[issue_unit].busy   = 1'b1;
            st_d.fu[issue_unit].opread = 1'b0;
            st_d.fu[issue_unit].fin    = 1'b0;
            st_d.fu[issue_unit].dst    = issue_dst;
            st_d.fu[issue_unit].src    = src_in;
            st_d.fu[issue_unit].older  = busy_vec & ~fu_wb;
            for (int k = 0; k < NUM_SRC; k++) begin
                st_d.fu[issue_unit].prod[k] = st_q.rs[src_in[k]].unit;
                st_d.fu[issue_unit].rdy[k]  = !st_q.rs[src_in[k]].vld ||
                    (gnt_any && st_q.rs[src_in[k]].unit == gnt_idx);
            end
            st_d.rs[issue_dst].vld  = 1'b1;
            st_d.rs[issue_dst].unit = issue_unit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sb_interlock_chk.sv
`timescale 1ns/1ps
module sb_interlock_chk
    import sb_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 issue_valid,
    input logic                 issue_ready,
    input logic [UNIT_W-1:0]    issue_unit,
    input logic [REG_W-1:0]     issue_dst,
    input logic [NUM_UNITS-1:0] busy_vec,
    input logic [NUM_REGS-1:0]  dst_pend,
    input logic [NUM_UNITS-1:0] fu_read,
    input logic [NUM_UNITS-1:0] fu_wb
);
    AST_ONE_WRITE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fu_wb)); // R6

    AST_ISSUE_CLAIMS_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && issue_ready |=> busy_vec[$past(issue_unit)]); // R1

    AST_ISSUE_CLAIMS_DST: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && issue_ready |=> dst_pend[$past(issue_dst)]); // R2

    generate
        for (genvar u = 0; u < NUM_UNITS; u++) begin : g_chk
            AST_READ_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
                fu_read[u] |=> !fu_read[u]); // R4
            AST_GRANT_FREES_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
                fu_wb[u] |=> !busy_vec[u]); // R9
            AST_READ_NOT_WITH_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
                fu_read[u] |-> !fu_wb[u]); // R3
        end
    endgenerate
endmodule

bind sb_interlock sb_interlock_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid),
    .issue_ready (issue_ready),
    .issue_unit  (issue_unit),
    .issue_dst   (issue_dst),
    .busy_vec    (busy_vec),
    .dst_pend    (dst_pend),
    .fu_read     (fu_read),
    .fu_wb       (fu_wb)
);

// File: tb/sb_interlock_tb_top.sv
`timescale 1ns/1ps
module sb_interlock_tb_top;
    import sb_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic issue_valid = 1'b0;
    logic issue_ready;
    logic [UNIT_W-1:0] issue_unit = '0;
    logic [REG_W-1:0]  issue_dst = '0, issue_srca = '0, issue_srcb = '0;
    logic [NUM_UNITS-1:0] fu_done, fu_read, fu_wb;

    always #2.5 clk = ~clk;

    sb_interlock dut_i (
        .clk(clk), .rst_n(rst_n),
        .issue_valid(issue_valid), .issue_ready(issue_ready),
        .issue_unit(issue_unit), .issue_dst(issue_dst),
        .issue_srca(issue_srca), .issue_srcb(issue_srcb),
        .fu_done(fu_done), .fu_read(fu_read), .fu_wb(fu_wb)
    );

    function automatic int lat_of(int u);
        case (u)
            FU_ADD:  return 2;
            FU_MUL:  return 4;
            FU_DIV:  return 10;
            default: return 1;
        endcase
    endfunction

    // Fixed-latency unit models
    int cnt [NUM_UNITS];
    always @(posedge clk) begin
        for (int u = 0; u < NUM_UNITS; u++) begin
            if (!rst_n)          cnt[u] <= 0;
            else if (fu_read[u]) cnt[u] <= lat_of(u);
            else if (cnt[u] != 0) cnt[u] <= cnt[u] - 1;
        end
    end
    always_comb for (int u = 0; u < NUM_UNITS; u++) fu_done[u] = (cnt[u] == 1);

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_fail = 0;
    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Reference model state
    logic tb_busy [NUM_UNITS], tb_read [NUM_UNITS], tb_fin [NUM_UNITS];
    int   tb_seq  [NUM_UNITS];
    logic [REG_W-1:0] tb_dst [NUM_UNITS];
    logic [REG_W-1:0] tb_src [NUM_UNITS][2];
    logic tb_pend [NUM_UNITS][2];
    int   tb_prod [NUM_UNITS][2];
    logic wr_vld  [NUM_REGS];
    int   wr_unit [NUM_REGS];
    int   seqn = 0, last_seq = 0;
    int   icyc [1024], rcyc [1024], gcyc [1024];
    logic [NUM_UNITS-1:0] erd, ewb;
    int best;
    bit blk, any_busy;

    initial begin
        for (int u = 0; u < NUM_UNITS; u++) begin
            tb_busy[u] = 0; tb_read[u] = 0; tb_fin[u] = 0; tb_seq[u] = 0; tb_dst[u] = '0;
            for (int k = 0; k < 2; k++) begin tb_src[u][k] = '0; tb_pend[u][k] = 0; tb_prod[u][k] = 0; end
        end
        for (int r = 0; r < NUM_REGS; r++) begin wr_vld[r] = 0; wr_unit[r] = 0; end
    end

    always @(negedge clk) if (rst_n) begin
        for (int u = 0; u < NUM_UNITS; u++)
            erd[u] = tb_busy[u] && !tb_read[u] && !tb_pend[u][0] && !tb_pend[u][1];
        chk(fu_read == erd, "R3 R4 read enable", int'(fu_read), int'(erd));

        best = -1;
        for (int u = 0; u < NUM_UNITS; u++) if (tb_busy[u] && tb_fin[u]) begin
            blk = 0;
            for (int v = 0; v < NUM_UNITS; v++)
                if (v != u && tb_busy[v] && !tb_read[v] && tb_seq[v] < tb_seq[u] &&
                    (tb_src[v][0] == tb_dst[u] || tb_src[v][1] == tb_dst[u])) blk = 1;
            if (!blk && (best < 0 || tb_seq[u] < tb_seq[best])) best = u;
        end
        ewb = '0;
        if (best >= 0) ewb[best] = 1'b1;
        chk(fu_wb == ewb, "R6 R7 R8 R9 write grant", int'(fu_wb), int'(ewb));

        if (issue_valid)
            chk(issue_ready == (!tb_busy[issue_unit] && !wr_vld[issue_dst]),
                "R1 R2 issue ready", int'(issue_ready),
                int'(!tb_busy[issue_unit] && !wr_vld[issue_dst]));

        for (int u = 0; u < NUM_UNITS; u++) if (fu_wb[u]) begin
            tb_busy[u] = 0; tb_fin[u] = 0; tb_read[u] = 0;
            wr_vld[tb_dst[u]] = 0;
            gcyc[tb_seq[u]] = cyc;
            for (int w = 0; w < NUM_UNITS; w++)
                for (int k = 0; k < 2; k++)
                    if (tb_pend[w][k] && tb_prod[w][k] == u) tb_pend[w][k] = 0;
        end
        for (int u = 0; u < NUM_UNITS; u++) begin
            if (fu_read[u]) begin tb_read[u] = 1; rcyc[tb_seq[u]] = cyc; end
            if (fu_done[u] && tb_busy[u]) tb_fin[u] = 1;
        end
        if (issue_valid && issue_ready) begin
            tb_busy[issue_unit] = 1; tb_read[issue_unit] = 0; tb_fin[issue_unit] = 0;
            tb_dst[issue_unit] = issue_dst;
            tb_src[issue_unit][0] = issue_srca;
            tb_src[issue_unit][1] = issue_srcb;
            tb_pend[issue_unit][0] = wr_vld[issue_srca];
            tb_prod[issue_unit][0] = wr_unit[issue_srca];
            tb_pend[issue_unit][1] = wr_vld[issue_srcb];
            tb_prod[issue_unit][1] = wr_unit[issue_srcb];
            wr_vld[issue_dst] = 1; wr_unit[issue_dst] = int'(issue_unit);
            tb_seq[issue_unit] = seqn; icyc[seqn] = cyc; last_seq = seqn;
            seqn++;
        end
    end

    task automatic issue(int u, int d, int a, int b);
        issue_valid = 1'b1;
        issue_unit = UNIT_W'(u); issue_dst = REG_W'(d);
        issue_srca = REG_W'(a);  issue_srcb = REG_W'(b);
        do @(negedge clk); while (!issue_ready);
        @(posedge clk); #1;
        issue_valid = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic drain();
        do begin
            @(posedge clk); #1;
            any_busy = 0;
            for (int u = 0; u < NUM_UNITS; u++) if (tb_busy[u]) any_busy = 1;
        end while (any_busy);
        idle(2);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired, actual=hung expected=done");
        finish_run();
    end

    initial begin
        int s0, s1, s2, exp_i, exp_r;
        bit stall;
        logic [15:0] lf;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(issue_ready == 1'b1, "R10 ready after reset", int'(issue_ready), 1);
        chk(fu_read == '0, "R10 no read after reset", int'(fu_read), 0);
        chk(fu_wb == '0, "R10 no grant after reset", int'(fu_wb), 0);
        @(posedge clk); #1;

        // Write-after-read: divide, dependent add, fast logic overwriting add source
        issue(FU_DIV, 1, 2, 3); s0 = last_seq;
        issue(FU_ADD, 5, 1, 4); s1 = last_seq;
        issue(FU_LOG, 4, 6, 7); s2 = last_seq;
        drain();
        chk(icyc[s1] == icyc[s0] + 1, "R5 dependent issues next clock", icyc[s1], icyc[s0] + 1);
        chk(icyc[s2] == icyc[s0] + 2, "R5 third issues next clock", icyc[s2], icyc[s0] + 2);
        chk(gcyc[s0] == icyc[s0] + 12, "R9 divide grant", gcyc[s0], icyc[s0] + 12);
        chk(rcyc[s1] == gcyc[s0] + 1, "R3 waits for producer", rcyc[s1], gcyc[s0] + 1);
        chk(rcyc[s2] == icyc[s2] + 1, "R4 independent read", rcyc[s2], icyc[s2] + 1);
        chk(gcyc[s2] == gcyc[s0] + 2, "R8 write held until read", gcyc[s2], gcyc[s0] + 2);

        // Three units finishing together
        issue(FU_MUL, 1, 0, 0); s0 = last_seq;
        idle(1);
        issue(FU_ADD, 2, 0, 0); s1 = last_seq;
        issue(FU_LOG, 3, 0, 0); s2 = last_seq;
        drain();
        chk(gcyc[s0] == icyc[s0] + 6, "R7 oldest first", gcyc[s0], icyc[s0] + 6);
        chk(gcyc[s1] == gcyc[s0] + 1, "R7 second oldest", gcyc[s1], gcyc[s0] + 1);
        chk(gcyc[s2] == gcyc[s0] + 2, "R7 youngest last", gcyc[s2], gcyc[s0] + 2);

        // Pair sweep: every unit pair with each dependency pattern
        for (int u1 = 0; u1 < NUM_UNITS; u1++)
            for (int u2 = 0; u2 < NUM_UNITS; u2++)
                for (int dep = 0; dep < 4; dep++) begin
                    issue(u1, 0, 1, 2); s0 = last_seq;
                    case (dep)
                        0: issue(u2, 3, 4, 5);
                        1: issue(u2, 3, 0, 4);
                        2: issue(u2, 0, 4, 5);
                        default: issue(u2, 1, 4, 5);
                    endcase
                    s1 = last_seq;
                    drain();
                    stall = (u1 == u2) || (dep == 2);
                    exp_i = stall ? gcyc[s0] + 1 : icyc[s0] + 1;
                    chk(icyc[s1] == exp_i, stall ? "R1 R2 stall until grant" : "R5 back to back",
                        icyc[s1], exp_i);
                    chk(gcyc[s0] == icyc[s0] + lat_of(u1) + 2, "R9 grant after done",
                        gcyc[s0], icyc[s0] + lat_of(u1) + 2);
                    exp_r = icyc[s1] + 1;
                    if (dep == 1 && gcyc[s0] + 1 > exp_r) exp_r = gcyc[s0] + 1;
                    chk(rcyc[s1] == exp_r, "R3 R4 read timing", rcyc[s1], exp_r);
                end

        // Pseudo-random stream
        lf = 16'hACE1;
        for (int n = 0; n < 400; n++) begin
            for (int k = 0; k < 11; k++) lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            issue(int'(lf[1:0]), int'(lf[4:2]), int'(lf[7:5]), int'(lf[10:8]));
            if (lf[11] && lf[12]) idle(1);
        end
        drain();
        finish_run();
    end
endmodule